// File: doc/BRIEF.md
# Descriptor-Driven Minor/Major Loop DMA Engine

This block is a single-channel memory-to-memory mover. Software programs a small descriptor through a register port. The descriptor holds a source byte address, a destination byte address, a per-request byte count, signed per-word address steps, signed end-of-run adjustments, a live iteration counter and a reload value. A request comes either from a self-clearing start bit or from a peripheral request line, and the line counts only while its enable bit is set. Each request copies one burst of words, the minor loop, over a word-wide memory port. The working addresses and the decremented counter are then written back into the descriptor. When the counter reaches zero the major loop is complete: the counter reloads, the end-of-run adjustments are applied, a completion flag is set, and interrupts or request disabling happen as configured.

A descriptor that cannot be executed is rejected before any memory access. Such a descriptor has a zero byte count, a zero iteration count, or an address, step or adjustment that is not word aligned. The engine is a five-state machine. `IDLE` waits for a request and goes to `CHECK` on one. `CHECK` validates the descriptor; it returns to `IDLE` on an error and otherwise goes to `READ`. `READ` and `WRITE` alternate once per word. `WRITE` goes to `WBACK` after the last word of the burst, and `WBACK` returns to `IDLE`.

Top module: `dma_loop_engine`

## Requirements
- R1: After reset every descriptor field and every control/status bit reads zero, `irq` and `done` are low and no memory access is made.
- R2: Service starts when the start bit (control bit 0) is set, or when `hw_req` is high while the request-enable bit (control bit 6) is set; `hw_req` with bit 6 clear starts nothing and leaves the descriptor unchanged.
- R3: The start bit reads zero once service has begun. The busy bit (control bit 1) is high while words are moved and during write-back, and it is never high for a rejected descriptor.
- R4: One request moves byte-count/4 words. Each word is a read at the working source address followed, the next cycle, by a write of that data to the working destination address. After each word the source step is added to the working source address and the destination step to the working destination address.
- R5: At the end of each minor loop the working source address, the working destination address and the iteration count decremented by one are written back into the descriptor.
- R6: When the decremented count is zero (major loop complete), the count reloads from the reload value, and the source and destination adjustments are added to the written-back addresses.
- R7: Major completion sets the done bit (control bit 2) and the `done` output. A control write with bit 2 at zero clears it, and a write with bit 2 at one leaves it unchanged.
- R8: If the auto-disable bit (control bit 3) is set, major completion clears the request-enable bit.
- R9: The interrupt flag (control bit 8, also `irq`) is set when the half-interrupt enable (bit 4) is set and the decremented count is nonzero and equals the reload value divided by two, rounded down. It is also set when the completion-interrupt enable (bit 5) is set and the major loop completes. The flag is sticky, and a control write with bit 8 at zero clears it.
- R10: A zero byte count, a zero reload value, a zero live count, or any address, step, adjustment or byte count not a multiple of 4 sets the error bit (control bit 7) and makes no memory access. A control write with bit 7 at zero clears it.
- R11: Writes to descriptor registers 0 to 5 are ignored while the engine is not in `IDLE`.
- R12: The register map is as follows. Register 0 is the source address and register 1 the destination address. Register 2 is the byte count. Register 3 holds the source step in bits 15:0 and the destination step in bits 31:16. Register 4 holds the source adjustment in bits 15:0 and the destination adjustment in bits 31:16. Register 5 holds the live count from bit 0 and the reload value from bit 16. Register 6 is control/status. Steps and adjustments are two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for read and write |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| hw_req | input | 1 | Peripheral service request |
| mem_rd | output | 1 | Memory read strobe; data returns next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| irq | output | 1 | Sticky interrupt flag |
| done | output | 1 | Major loop completion flag |

## Verification
The bench builds the engine with 16-bit addresses, 32-bit words, an 8-bit byte count and a 4-bit iteration counter. This keeps every counter value small enough that a full sweep is cheap. It sweeps bursts of one to three words against major loops of one to five iterations. Each combination runs with positive, zero and negative steps, with both request sources, and with the interrupt and auto-disable options varied. This covers the single-iteration case, where the half point coincides with completion, as well as odd and even reload values. Directed runs add rejected descriptors, an ignored request line and descriptor writes made while the engine is busy.

// File: rtl/dma_loop_pkg.sv
package dma_loop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ,
        ST_WRITE,
        ST_WBACK
    } eng_state_t;

    localparam logic [2:0] RA_SRC   = 3'd0;
    localparam logic [2:0] RA_DST   = 3'd1;
    localparam logic [2:0] RA_COUNT = 3'd2;
    localparam logic [2:0] RA_STEP  = 3'd3;
    localparam logic [2:0] RA_ADJ   = 3'd4;
    localparam logic [2:0] RA_ITER  = 3'd5;
    localparam logic [2:0] RA_CTRL  = 3'd6;

    localparam int CB_START = 0;
    localparam int CB_BUSY  = 1;
    localparam int CB_DONE  = 2;
    localparam int CB_ADIS  = 3;
    localparam int CB_HALF  = 4;
    localparam int CB_FULL  = 5;
    localparam int CB_REQEN = 6;
    localparam int CB_ERR   = 7;
    localparam int CB_INT   = 8;

endpackage

// File: rtl/dma_desc_regs.sv
module dma_desc_regs
    import dma_loop_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int NBW = 8,
    parameter int CW  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [2:0]           addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic                 busy,
    input  logic                 active,
    input  logic                 clr_start,
    input  logic                 set_err,
    input  logic                 wb,
    input  logic [AW-1:0]        wb_src,
    input  logic [AW-1:0]        wb_dst,
    input  logic [CW-1:0]        wb_count,
    input  logic                 wb_major,
    input  logic                 wb_half,
    output logic [AW-1:0]        src,
    output logic [AW-1:0]        dst,
    output logic [NBW-1:0]       nbytes,
    output logic [AW-1:0]        sstep,
    output logic [AW-1:0]        dstep,
    output logic [AW-1:0]        sadj,
    output logic [AW-1:0]        dadj,
    output logic [CW-1:0]        count,
    output logic [CW-1:0]        reload,
    output logic                 start,
    output logic                 reqen,
    output logic                 adis,
    output logic                 half_en,
    output logic                 full_en,
    output logic                 done_f,
    output logic                 err_f,
    output logic                 int_f
);

    localparam int HW = DW / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src <= '0; dst <= '0; nbytes <= '0;
            sstep <= '0; dstep <= '0; sadj <= '0; dadj <= '0;
            count <= '0; reload <= '0;
            start <= 1'b0; reqen <= 1'b0; adis <= 1'b0;
            half_en <= 1'b0; full_en <= 1'b0;
            done_f <= 1'b0; err_f <= 1'b0; int_f <= 1'b0;
        end else begin
            if (we && !busy) begin
                case (addr)
                    RA_SRC:   src    <= wdata[AW-1:0];
                    RA_DST:   dst    <= wdata[AW-1:0];
                    RA_COUNT: nbytes <= wdata[NBW-1:0];
                    RA_STEP: begin
                        sstep <= AW'($signed(wdata[HW-1:0]));
                        dstep <= AW'($signed(wdata[DW-1:HW]));
                    end
                    RA_ADJ: begin
                        sadj <= AW'($signed(wdata[HW-1:0]));
                        dadj <= AW'($signed(wdata[DW-1:HW]));
                    end
                    RA_ITER: begin
                        count  <= wdata[CW-1:0];
                        reload <= wdata[HW+CW-1:HW];
                    end
                    default: ;
                endcase
            end
            if (we && addr == RA_CTRL) begin
                start   <= wdata[CB_START];
                adis    <= wdata[CB_ADIS];
                half_en <= wdata[CB_HALF];
                full_en <= wdata[CB_FULL];
                reqen   <= wdata[CB_REQEN];
                done_f  <= done_f & wdata[CB_DONE];
                err_f   <= err_f & wdata[CB_ERR];
                int_f   <= int_f & wdata[CB_INT];
            end
            if (clr_start) start <= 1'b0;
            if (set_err)   err_f <= 1'b1;
            if (wb) begin
                src   <= wb_src;
                dst   <= wb_dst;
                count <= wb_count;
                if (wb_major) begin
                    done_f <= 1'b1;
                    if (adis)    reqen <= 1'b0;
                    if (full_en) int_f <= 1'b1;
                end
                if (wb_half && half_en) int_f <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_SRC:   rdata[AW-1:0]  = src;
            RA_DST:   rdata[AW-1:0]  = dst;
            RA_COUNT: rdata[NBW-1:0] = nbytes;
            RA_STEP:  rdata = {HW'(dstep), HW'(sstep)};
            RA_ADJ:   rdata = {HW'(dadj), HW'(sadj)};
            RA_ITER: begin
                rdata[CW-1:0]     = count;
                rdata[HW+CW-1:HW] = reload;
            end
            RA_CTRL: begin
                rdata[CB_START] = start;
                rdata[CB_BUSY]  = active;
                rdata[CB_DONE]  = done_f;
                rdata[CB_ADIS]  = adis;
                rdata[CB_HALF]  = half_en;
                rdata[CB_FULL]  = full_en;
                rdata[CB_REQEN] = reqen;
                rdata[CB_ERR]   = err_f;
                rdata[CB_INT]   = int_f;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_loop_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int NBW = 8,
    parameter int CW  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   src,
    input  logic [AW-1:0]   dst,
    input  logic [NBW-1:0]  nbytes,
    input  logic [AW-1:0]   sstep,
    input  logic [AW-1:0]   dstep,
    input  logic [AW-1:0]   sadj,
    input  logic [AW-1:0]   dadj,
    input  logic [CW-1:0]   count,
    input  logic [CW-1:0]   reload,
    input  logic            start,
    input  logic            reqen,
    input  logic            hw_req,
    output logic            busy,
    output logic            active,
    output logic            clr_start,
    output logic            set_err,
    output logic            wb,
    output logic [AW-1:0]   wb_src,
    output logic [AW-1:0]   wb_dst,
    output logic [CW-1:0]   wb_count,
    output logic            wb_major,
    output logic            wb_half,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata
);

    localparam int BYTES = DW / 8;
    localparam int LB    = $clog2(BYTES);

    eng_state_t state, nxt;
    logic [AW-1:0]  src_w, dst_w;
    logic [NBW-1:0] rem_w;
    logic           go, cfg_err, last_word;
    logic [CW-1:0]  dec_count;

    assign go        = start | (reqen & hw_req);
    assign last_word = (rem_w == NBW'(BYTES));
    assign dec_count = count - CW'(1);
    assign cfg_err   = (nbytes == '0) || (reload == '0) || (count == '0) ||
                       (|{src[LB-1:0], dst[LB-1:0], nbytes[LB-1:0],
                          sstep[LB-1:0], dstep[LB-1:0], sadj[LB-1:0], dadj[LB-1:0]});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (go) nxt = ST_CHECK;
            ST_CHECK: nxt = cfg_err ? ST_IDLE : ST_READ;
            ST_READ:  nxt = ST_WRITE;
            ST_WRITE: nxt = last_word ? ST_WBACK : ST_READ;
            ST_WBACK: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_w <= '0; dst_w <= '0; rem_w <= '0;
        end else if (state == ST_IDLE && go) begin
            src_w <= src; dst_w <= dst; rem_w <= nbytes;
        end else if (state == ST_WRITE) begin
            src_w <= src_w + sstep;
            dst_w <= dst_w + dstep;
            rem_w <= rem_w - NBW'(BYTES);
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        active    = (state == ST_READ) || (state == ST_WRITE) || (state == ST_WBACK);
        clr_start = (state == ST_IDLE) && go;
        set_err   = (state == ST_CHECK) && cfg_err;
        mem_rd    = (state == ST_READ);
        mem_wr    = (state == ST_WRITE);
        mem_addr  = (state == ST_WRITE) ? dst_w : src_w;
        mem_wdata = mem_rdata;
        wb        = (state == ST_WBACK);
        wb_major  = (dec_count == '0);
        wb_half   = (dec_count != '0) && (dec_count == (reload >> 1));
        wb_count  = wb_major ? reload : dec_count;
        wb_src    = wb_major ? src_w + sadj : src_w;
        wb_dst    = wb_major ? dst_w + dadj : dst_w;
    end

    p_write_follows_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));
    p_wb_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb |-> $past(mem_wr));
    p_err_no_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |=> (!active && !mem_rd && !mem_wr));

endmodule

// File: rtl/dma_loop_engine.sv
module dma_loop_engine
    import dma_loop_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int NBW = 8,
    parameter int CW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [2:0]     reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic           hw_req,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic           irq,
    output logic           done
);

    logic [AW-1:0]  src, dst, sstep, dstep, sadj, dadj, wb_src, wb_dst;
    logic [NBW-1:0] nbytes;
    logic [CW-1:0]  count, reload, wb_count;
    logic start, reqen, adis, half_en, full_en, err_f;
    logic busy, active, clr_start, set_err, wb, wb_major, wb_half;

    dma_desc_regs #(.AW(AW), .DW(DW), .NBW(NBW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .busy(busy), .active(active), .clr_start(clr_start), .set_err(set_err),
        .wb(wb), .wb_src(wb_src), .wb_dst(wb_dst), .wb_count(wb_count),
        .wb_major(wb_major), .wb_half(wb_half),
        .src(src), .dst(dst), .nbytes(nbytes), .sstep(sstep), .dstep(dstep),
        .sadj(sadj), .dadj(dadj), .count(count), .reload(reload),
        .start(start), .reqen(reqen), .adis(adis), .half_en(half_en),
        .full_en(full_en), .done_f(done), .err_f(err_f), .int_f(irq)
    );

    dma_xfer_fsm #(.AW(AW), .DW(DW), .NBW(NBW), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .src(src), .dst(dst), .nbytes(nbytes), .sstep(sstep), .dstep(dstep),
        .sadj(sadj), .dadj(dadj), .count(count), .reload(reload),
        .start(start), .reqen(reqen), .hw_req(hw_req),
        .busy(busy), .active(active), .clr_start(clr_start), .set_err(set_err),
        .wb(wb), .wb_src(wb_src), .wb_dst(wb_dst), .wb_count(wb_count),
        .wb_major(wb_major), .wb_half(wb_half),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_start |=> !start);
    p_done_on_major_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb && wb_major) |=> done);
    p_autodisable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb && wb_major && adis) |=> !reqen);
    p_half_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wb && wb_half && half_en) |=> irq);
    p_err_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |=> err_f);

endmodule

// File: tb/sim_dma_loop_engine.sv
`timescale 1ns/1ps
module sim_dma_loop_engine;

    localparam int AW = 16, DW = 32, NBW = 8, CW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_we = 1'b0, hw_req = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0, reg_rdata, mem_wdata, mem_rdata;
    logic mem_rd, mem_wr, irq, done;
    logic [15:0] mem_addr;

    logic [31:0] mem    [0:255];
    logic [31:0] shadow [0:255];
    int n_cmp = 0, n_bad = 0, acc_cnt = 0;
    bit saw_busy = 0, finished = 0;

    always #4 clk = ~clk;

    dma_loop_engine #(.AW(AW), .DW(DW), .NBW(NBW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req(hw_req),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq), .done(done));

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
        if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
        if (mem_rd || mem_wr) acc_cnt <= acc_cnt + 1;
    end

    always @(negedge clk) if (reg_addr == 3'd6 && reg_rdata[1]) saw_busy = 1;

    function automatic logic [31:0] initv(int i);
        return {16'hC0DE, 8'(i), ~8'(i)};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wreg(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic idle_wait(int n);
        reg_addr = 3'd6;
        repeat (n) @(negedge clk);
    endtask

    task automatic mem_init();
        for (int i = 0; i < 256; i++) begin
            mem[i] = initv(i); shadow[i] = initv(i);
        end
    endtask

    task automatic load_desc(logic [15:0] s, logic [15:0] d, int nb,
                             logic [15:0] ss, logic [15:0] ds,
                             logic [15:0] sa, logic [15:0] da, int cnt, int rl);
        wreg(3'd0, {16'h0, s});
        wreg(3'd1, {16'h0, d});
        wreg(3'd2, 32'(nb));
        wreg(3'd3, {ds, ss});
        wreg(3'd4, {da, sa});
        wreg(3'd5, (32'(rl) << 16) | 32'(cnt));
    endtask

    task automatic run_case(int nb, int bi, logic [15:0] ss, logic [15:0] ds,
                            logic [15:0] sa, logic [15:0] da, logic [15:0] d0,
                            bit hw, bit hen, bit fen, bit adis);
        logic [31:0] base, v;
        logic [15:0] s, d;
        int words, start_acc, bad_idx;
        bit exp_int;
        mem_init();
        load_desc(16'h0040, d0, nb, ss, ds, sa, da, bi, bi);
        base = (32'(adis) << 3) | (32'(hen) << 4) | (32'(fen) << 5) | (32'(hw) << 6);
        wreg(3'd6, base);
        words = nb / 4; s = 16'h0040; d = d0; exp_int = 0;
        start_acc = acc_cnt;
        for (int k = 0; k < bi; k++) begin
            int nc;
            saw_busy = 0;
            if (hw) begin
                @(negedge clk); hw_req = 1'b1;
                @(negedge clk); hw_req = 1'b0;
            end else begin
                wreg(3'd6, base | 32'h185);
            end
            idle_wait(2 * words + 6);
            for (int j = 0; j < words; j++) begin
                shadow[d[9:2]] = initv(int'(s[9:2]));
                s = s + ss; d = d + ds;
            end
            nc = bi - 1 - k;
            if (nc == 0) begin s = s + sa; d = d + da; end
            if (hen && nc != 0 && nc == bi / 2) exp_int = 1;
            if (fen && nc == 0) exp_int = 1;
            check("R3 busy seen during minor loop", 32'(saw_busy), 32'd1);
            rreg(3'd0, v); check("R5/R6 source write-back", v, {16'h0, s});
            rreg(3'd1, v); check("R5/R6 destination write-back", v, {16'h0, d});
            rreg(3'd5, v); check("R5/R6 live count", 32'(v[3:0]), 32'(nc == 0 ? bi : nc));
            rreg(3'd6, v);
            check("R3 start self-clears, busy low", 32'(v[1:0]), 32'd0);
            check("R7 done bit", 32'(v[2]), 32'(nc == 0));
            check("R9 interrupt flag", {30'd0, v[8], irq}, {30'd0, exp_int, exp_int});
            check("R8 request enable", 32'(v[6]), 32'(hw && !(adis && nc == 0)));
        end
        check("R4 access count", 32'(acc_cnt - start_acc), 32'(2 * words * bi));
        bad_idx = -1;
        for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i] && bad_idx < 0) bad_idx = i;
        check("R4 memory image mismatch index", 32'(bad_idx), 32'hFFFF_FFFF);
        wreg(3'd6, base | 32'h004);
        check("R7 done kept, R9 irq cleared", {30'd0, done, irq}, 32'd2);
        wreg(3'd6, base);
        check("R7 done cleared", 32'(done), 32'd0);
    endtask

    task automatic err_case(string tag, int nb, logic [15:0] s, int cnt, int rl);
        logic [31:0] v;
        int a0;
        mem_init();
        load_desc(s, 16'h0200, nb, 16'h4, 16'h4, 16'h0, 16'h0, cnt, rl);
        wreg(3'd6, 32'h0);
        a0 = acc_cnt; saw_busy = 0;
        wreg(3'd6, 32'h1);
        idle_wait(12);
        rreg(3'd6, v);
        check({"R10 error bit ", tag}, 32'(v[7]), 32'd1);
        check({"R10 no access ", tag}, 32'(acc_cnt - a0), 32'd0);
        check({"R10/R3 never busy ", tag}, 32'(saw_busy), 32'd0);
        wreg(3'd6, 32'h0);
        rreg(3'd6, v);
        check({"R10 error cleared ", tag}, 32'(v[7]), 32'd0);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int a0;
        mem_init();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int r = 0; r < 7; r++) begin
            rreg(3'(r), v);
            check($sformatf("R1 reset reg %0d", r), v, 32'd0);
        end
        check("R1 irq/done after reset", {30'd0, irq, done}, 32'd0);
        check("R1 no memory access after reset", 32'(acc_cnt), 32'd0);

        // R12 field placement readback
        load_desc(16'h0044, 16'h0208, 8, 16'hFFF8, 16'h000C, 16'h0010, 16'hFFE0, 3, 7);
        rreg(3'd3, v); check("R12 step register", v, 32'h000C_FFF8);
        rreg(3'd4, v); check("R12 adjust register", v, 32'hFFE0_0010);
        rreg(3'd5, v); check("R12 iteration register", v, 32'h0007_0003);
        rreg(3'd2, v); check("R12 count register", v, 32'd8);

        // R2 request line ignored when enable is clear
        wreg(3'd6, 32'h0);
        a0 = acc_cnt;
        @(negedge clk); hw_req = 1'b1;
        repeat (3) @(negedge clk); hw_req = 1'b0;
        idle_wait(10);
        check("R2 hw_req ignored, no access", 32'(acc_cnt - a0), 32'd0);
        rreg(3'd5, v); check("R2 hw_req ignored, count kept", v, 32'h0007_0003);
        rreg(3'd0, v); check("R2 hw_req ignored, source kept", v, 32'h0000_0044);

        // R11 descriptor writes while busy
        mem_init();
        load_desc(16'h0040, 16'h0200, 12, 16'h4, 16'h4, 16'h0, 16'h0, 2, 2);
        wreg(3'd6, 32'h1);
        wreg(3'd0, 32'h0000_0FFC);
        wreg(3'd5, 32'h0009_0009);
        idle_wait(12);
        rreg(3'd0, v); check("R11 source write while busy ignored", v, 32'h0000_004C);
        rreg(3'd5, v); check("R11 count write while busy ignored", v, 32'h0002_0001);

        // R10 rejected descriptors
        err_case("zero count", 0, 16'h0040, 2, 2);
        err_case("zero reload", 4, 16'h0040, 2, 0);
        err_case("zero live count", 4, 16'h0040, 0, 2);
        err_case("misaligned source", 4, 16'h0042, 2, 2);
        err_case("misaligned bytes", 6, 16'h0040, 2, 2);

        // R2/R4..R9 sweep
        for (int nw = 1; nw <= 3; nw++)
            for (int bi = 1; bi <= 5; bi++)
                for (int oc = 0; oc < 3; oc++)
                    for (int hw = 0; hw < 2; hw++) begin
                        bit hen, fen, ad;
                        hen = ((bi + oc) % 2) == 1;
                        fen = ((nw + hw) % 2) == 1;
                        ad  = (oc == 1);
                        case (oc)
                            0: run_case(4 * nw, bi, 16'h0004, 16'h0004, 16'hFFF0, 16'h0020,
                                        16'h0200, hw[0], hen, fen, ad);
                            1: run_case(4 * nw, bi, 16'h0008, 16'h0000, 16'h0000, 16'h0004,
                                        16'h0200, hw[0], hen, fen, ad);
                            default: run_case(4 * nw, bi, 16'h0004, 16'hFFFC, 16'h0008, 16'hFFF8,
                                        16'h0300, hw[0], hen, fen, ad);
                        endcase
                    end

        finished = 1;
        report();
        $finish;
    end

endmodule